// File: doc/BRIEF.md
# Track Block Address Sequencer

This block walks a block transfer across a rotating storage medium, one word slot at a time. A command carries a begin address and an end address. Each is 19 bits wide and holds a word index within a track and a track index. The block first checks the command. If either track index is outside the usable range, or the end lies before the begin, it reports an address error and makes no access. Otherwise it presents the begin address and labels it as the preamble slot. Each word-slot pulse then moves it forward by one location until the end location has been handled.

On a read, the first slot must show a detected preamble. If no preamble is seen there, the block abandons the transfer and flags a sync-detect error. Writes never look at the preamble detector. A block of N data words therefore spans N+1 locations, and a read must be issued with the same begin and end pair that was used to write it. Stepping past word 1023 moves to word 0 of the next track, so a block can cross track boundaries.

Top module: `trk_blk_seq`

## Requirements
- R1: Address layout: bits 9..0 hold the word index, with the LSB at bit 0. Bits 18..10 hold the track index, with the LSB at bit 10. `cur_addr` uses the same layout.
- R2: If the begin or the end track index is 384 or higher, a `start` in idle gives `addr_err` high for exactly one cycle on the next clock. `busy` stays low and no slot is presented.
- R3: If the end address, read as an unsigned 19-bit number, is below the begin address, the command is rejected in the same way as in R2.
- R4: A valid `start` in idle raises `busy` on the next clock, with `cur_addr` equal to the begin address and `is_preamble` high.
- R5: Each `slot_pulse` while busy advances `cur_addr` by one location. Word 1023 wraps to word 0 and the track index goes up by one. With no pulse, `cur_addr` holds.
- R6: `is_preamble` is high only while the begin location is presented and is low on every later location.
- R7: The slot pulse taken at the end location makes `done` high for one cycle on the next clock, with `busy` low. A block with begin B and end E accepts exactly E-B+1 slot pulses.
- R8: On a read (`rd_mode`=1 at start), if `pre_seen` is low with the first slot pulse, the next clock gives `sync_err` high for one cycle and `busy` low, and `done` is not raised. On a write, `pre_seen` has no effect.
- R9: A `start` while busy is ignored. The address sequence of the running block continues unchanged.
- R10: After reset, `busy`, `done`, `addr_err`, `sync_err` and `is_preamble` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe, taken only in idle |
| rd_mode | input | 1 | 1 = read transfer, 0 = write transfer |
| begin_addr | input | 19 | Begin location {track, word} |
| end_addr | input | 19 | End location {track, word} |
| slot_pulse | input | 1 | One pulse per word slot passing the head |
| pre_seen | input | 1 | Preamble detected, sampled with the first slot pulse |
| busy | output | 1 | Transfer in progress |
| cur_addr | output | 19 | Location being handled {track, word} |
| is_preamble | output | 1 | Current location is the preamble slot |
| done | output | 1 | One-cycle pulse when the block is complete |
| addr_err | output | 1 | One-cycle pulse when a command is rejected |
| sync_err | output | 1 | One-cycle pulse when a read finds no preamble |

## Verification
The sweep places begin addresses on words 1021 to 1023 so that blocks cross track edges. A counter that failed to carry into the track field would wrap back onto the same track and show a wrong `cur_addr`. Track codes 383, 384 and 511 are tried on both the begin and the end address, and reversed pairs are tried too. An off-by-one limit would either reject track 383 or start a transfer on a track that does not exist. Zero-length blocks, where begin equals end, check that `done` follows the preamble slot alone. Reads without a preamble, and writes with the detector low, separate a design that aborts writes by mistake from one that lets a failed read run on.

// File: rtl/trk_blk_pkg.sv
// Package: shared types for the track block address sequencer.
// Assumes: nothing beyond a two-state control flow.
package trk_blk_pkg;

    // Control states of the sequencer
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/trk_range.sv
// Module: trk_range
// Checks that one {track, word} address has a track index below LIMIT.
// Assumes: the track field sits in the upper TRACK_W bits of the address.
module trk_range #(
    parameter int WORD_W      = 10,
    parameter int TRACK_W     = 9,
    parameter int TRACK_LIMIT = 384
) (
    input  logic [WORD_W+TRACK_W-1:0] addr,
    output logic                      in_range
);
    localparam int ADDR_W = WORD_W + TRACK_W;
    localparam logic [TRACK_W-1:0] LIM = TRACK_W'(TRACK_LIMIT);

    logic [TRACK_W-1:0] trk;

    // Split off the track field and compare it with the limit
    always_comb begin
        trk      = addr[ADDR_W-1:WORD_W];
        in_range = (trk < LIM);
    end
endmodule

// File: rtl/blk_cmd_check.sv
// Module: blk_cmd_check
// Validates a command: both tracks in range and end not before begin.
// Assumes: addresses are {track, word}, so numeric order equals slot order.
module blk_cmd_check #(
    parameter int WORD_W      = 10,
    parameter int TRACK_W     = 9,
    parameter int TRACK_LIMIT = 384
) (
    input  logic [WORD_W+TRACK_W-1:0] begin_addr,
    input  logic [WORD_W+TRACK_W-1:0] end_addr,
    output logic                      cmd_ok
);
    localparam int ADDR_W = WORD_W + TRACK_W;
    localparam int N_ADDR = 2;

    logic [ADDR_W-1:0] addr_set [N_ADDR];
    logic [N_ADDR-1:0] rng_ok;

    // Gather both command addresses for the range checkers
    always_comb begin
        addr_set[0] = begin_addr;
        addr_set[1] = end_addr;
    end

    for (genvar g = 0; g < N_ADDR; g++) begin : g_rng
        trk_range #(
            .WORD_W     (WORD_W),
            .TRACK_W    (TRACK_W),
            .TRACK_LIMIT(TRACK_LIMIT)
        ) u_rng (
            .addr    (addr_set[g]),
            .in_range(rng_ok[g])
        );
    end

    // Combine the range results with the ordering rule
    always_comb begin
        cmd_ok = (&rng_ok) && (end_addr >= begin_addr);
    end
endmodule

// File: rtl/blk_addr_ctr.sv
// Module: blk_addr_ctr
// Holds the current location and the latched end location.
// The word field wraps at its top value and carries into the track field.
// Assumes: load and step are never asserted together.
module blk_addr_ctr #(
    parameter int WORD_W  = 10,
    parameter int TRACK_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      step,
    input  logic [WORD_W+TRACK_W-1:0] begin_addr,
    input  logic [WORD_W+TRACK_W-1:0] end_addr,
    output logic [WORD_W+TRACK_W-1:0] cur_addr,
    output logic                      at_end
);
    localparam int ADDR_W = WORD_W + TRACK_W;
    localparam logic [WORD_W-1:0] WORD_TOP = {WORD_W{1'b1}};

    logic [WORD_W-1:0]  word_q;
    logic [TRACK_W-1:0] trk_q;
    logic [ADDR_W-1:0]  end_q;
    logic [WORD_W-1:0]  word_nx;
    logic [TRACK_W-1:0] trk_nx;

    // Next location: word plus one, carry into track on wrap
    always_comb begin
        if (word_q == WORD_TOP) begin
            word_nx = '0;
            trk_nx  = trk_q + TRACK_W'(1);
        end else begin
            word_nx = word_q + WORD_W'(1);
            trk_nx  = trk_q;
        end
    end

    // Location registers: load on command, advance on step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            trk_q  <= '0;
            end_q  <= '0;
        end else if (load) begin
            word_q <= begin_addr[WORD_W-1:0];
            trk_q  <= begin_addr[ADDR_W-1:WORD_W];
            end_q  <= end_addr;
        end else if (step) begin
            word_q <= word_nx;
            trk_q  <= trk_nx;
        end
    end

    // Present the location and the end match
    always_comb begin
        cur_addr = {trk_q, word_q};
        at_end   = (cur_addr == end_q);
    end
endmodule

// File: rtl/blk_seq_ctrl.sv
// Module: blk_seq_ctrl
// Control for one block transfer: accepts or rejects a command, counts
// slots, checks the preamble on reads and signals the end of the block.
// Assumes: slot_pulse is one cycle wide per word slot.
module blk_seq_ctrl
    import trk_blk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cmd_ok,
    input  logic rd_mode,
    input  logic slot_pulse,
    input  logic pre_seen,
    input  logic at_end,
    output logic load,
    output logic step,
    output logic busy,
    output logic first,
    output logic done,
    output logic addr_err,
    output logic sync_err
);
    seq_state_t state_q;
    logic       rd_q;
    logic       first_q;
    logic       no_pre;

    // Decode the load and step strobes for the address counter
    always_comb begin
        load   = (state_q == SEQ_IDLE) && start && cmd_ok;
        no_pre = first_q && rd_q && !pre_seen;
        step   = (state_q == SEQ_RUN) && slot_pulse && !no_pre && !at_end;
    end

    // State, mode latch and the one-cycle status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            rd_q     <= 1'b0;
            first_q  <= 1'b0;
            done     <= 1'b0;
            addr_err <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            done     <= 1'b0;
            addr_err <= 1'b0;
            sync_err <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        if (cmd_ok) begin
                            state_q <= SEQ_RUN;
                            rd_q    <= rd_mode;
                            first_q <= 1'b1;
                        end else begin
                            addr_err <= 1'b1;
                        end
                    end
                end
                SEQ_RUN: begin
                    if (slot_pulse) begin
                        first_q <= 1'b0;
                        if (no_pre) begin
                            sync_err <= 1'b1;
                            state_q  <= SEQ_IDLE;
                        end else if (at_end) begin
                            done    <= 1'b1;
                            state_q <= SEQ_IDLE;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Status presented to the top
    always_comb begin
        busy  = (state_q == SEQ_RUN);
        first = busy && first_q;
    end
endmodule

// File: rtl/trk_blk_seq.sv
// Module: trk_blk_seq (top)
// Sequences a block transfer from a begin to an end {track, word} address.
// The first location is the preamble slot.
// Assumes: the caller supplies one slot_pulse per word slot, plus the
// preamble detector result for reads.
module trk_blk_seq #(
    parameter int WORD_W      = 10,
    parameter int TRACK_W     = 9,
    parameter int TRACK_LIMIT = 384
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      rd_mode,
    input  logic [WORD_W+TRACK_W-1:0] begin_addr,
    input  logic [WORD_W+TRACK_W-1:0] end_addr,
    input  logic                      slot_pulse,
    input  logic                      pre_seen,
    output logic                      busy,
    output logic [WORD_W+TRACK_W-1:0] cur_addr,
    output logic                      is_preamble,
    output logic                      done,
    output logic                      addr_err,
    output logic                      sync_err
);
    logic cmd_ok;
    logic load;
    logic step;
    logic at_end;

    blk_cmd_check #(
        .WORD_W     (WORD_W),
        .TRACK_W    (TRACK_W),
        .TRACK_LIMIT(TRACK_LIMIT)
    ) u_chk (
        .begin_addr(begin_addr),
        .end_addr  (end_addr),
        .cmd_ok    (cmd_ok)
    );

    blk_addr_ctr #(
        .WORD_W (WORD_W),
        .TRACK_W(TRACK_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .begin_addr(begin_addr),
        .end_addr  (end_addr),
        .cur_addr  (cur_addr),
        .at_end    (at_end)
    );

    blk_seq_ctrl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_ok    (cmd_ok),
        .rd_mode   (rd_mode),
        .slot_pulse(slot_pulse),
        .pre_seen  (pre_seen),
        .at_end    (at_end),
        .load      (load),
        .step      (step),
        .busy      (busy),
        .first     (is_preamble),
        .done      (done),
        .addr_err  (addr_err),
        .sync_err  (sync_err)
    );
endmodule

// File: rtl/trk_blk_seq_chk.sv
// Module: trk_blk_seq_chk
// Checker bound to trk_blk_seq. It watches only the ports.
module trk_blk_seq_chk #(
    parameter int WORD_W      = 10,
    parameter int TRACK_W     = 9,
    parameter int TRACK_LIMIT = 384
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic                      slot_pulse,
    input logic                      busy,
    input logic [WORD_W+TRACK_W-1:0] cur_addr,
    input logic                      is_preamble,
    input logic                      done,
    input logic                      addr_err,
    input logic                      sync_err
);
    localparam int ADDR_W = WORD_W + TRACK_W;

    // R5: one slot pulse moves exactly one location
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(slot_pulse)) |->
            (cur_addr == $past(cur_addr) + ADDR_W'(1)));

    // R5: without a slot pulse the location holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(slot_pulse)) |-> $stable(cur_addr));

    // R2: a presented location never has an invalid track
    a_r2_track_valid: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cur_addr[ADDR_W-1:WORD_W] < TRACK_W'(TRACK_LIMIT)));

    // R2: an address error follows a start and starts no transfer
    a_r2_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (!busy && $past(start)));

    // R4: a new transfer opens on the preamble slot
    a_r4_opens_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> is_preamble);

    // R6: the preamble flag clears after the first slot is taken
    a_r6_preamble_once: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(slot_pulse)) |-> !is_preamble);

    // R7: done ends the transfer
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: a sync error ends the transfer
    a_r8_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> !busy);

    // R7: at most one status pulse at a time
    a_r7_one_status: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, addr_err, sync_err}));
endmodule

bind trk_blk_seq trk_blk_seq_chk #(
    .WORD_W     (WORD_W),
    .TRACK_W    (TRACK_W),
    .TRACK_LIMIT(TRACK_LIMIT)
) u_chk_bind (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .slot_pulse (slot_pulse),
    .busy       (busy),
    .cur_addr   (cur_addr),
    .is_preamble(is_preamble),
    .done       (done),
    .addr_err   (addr_err),
    .sync_err   (sync_err)
);

// File: tb/sim_trk_blk_seq.sv
// Bench for trk_blk_seq. It sweeps block lengths across track edges, the
// limits of the track range, read and write modes and preamble outcomes.
module sim_trk_blk_seq;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rd_mode = 1'b0;
    logic [AW-1:0] begin_addr = '0;
    logic [AW-1:0] end_addr = '0;
    logic          slot_pulse = 1'b0;
    logic          pre_seen = 1'b0;
    logic          busy;
    logic [AW-1:0] cur_addr;
    logic          is_preamble;
    logic          done;
    logic          addr_err;
    logic          sync_err;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    trk_blk_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .rd_mode    (rd_mode),
        .begin_addr (begin_addr),
        .end_addr   (end_addr),
        .slot_pulse (slot_pulse),
        .pre_seen   (pre_seen),
        .busy       (busy),
        .cur_addr   (cur_addr),
        .is_preamble(is_preamble),
        .done       (done),
        .addr_err   (addr_err),
        .sync_err   (sync_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int trk, input int wrd);
        return AW'(trk * 1024 + wrd);
    endfunction

    // Issue a command and run it slot by slot. pre is the detector value
    // for the first slot. gap adds idle cycles between slots.
    task automatic run_blk(input logic [AW-1:0] b, input logic [AW-1:0] e,
                           input logic rd, input logic pre, input int gap,
                           input logic poke);
        int n;
        logic bad;
        @(negedge clk);
        start = 1'b1; rd_mode = rd; begin_addr = b; end_addr = e;
        @(negedge clk);
        start = 1'b0;
        bad = (b[18:10] >= 9'd384) || (e[18:10] >= 9'd384) || (e < b);
        if (bad) begin
            chk("R2/R3 addr_err", addr_err, 1);
            chk("R2/R3 busy low", busy, 0);
            @(negedge clk);
            chk("R2 addr_err one cycle", addr_err, 0);
            return;
        end
        chk("R4 busy", busy, 1);
        chk("R4 addr_err low", addr_err, 0);
        n = int'(e - b) + 1;
        for (int i = 0; i < n; i++) begin
            chk("R5 cur_addr", cur_addr, b + AW'(i));
            chk("R6 is_preamble", is_preamble, (i == 0));
            chk("R1 word field", cur_addr[9:0], (b + AW'(i)) & 19'h3FF);
            if (poke && i == 1) begin
                start = 1'b1; begin_addr = mk(7, 7); end_addr = mk(8, 8);
            end
            slot_pulse = 1'b1; pre_seen = pre;
            @(negedge clk);
            slot_pulse = 1'b0; pre_seen = 1'b0; start = 1'b0;
            if (i == 0 && rd && !pre) begin
                chk("R8 sync_err", sync_err, 1);
                chk("R8 busy low", busy, 0);
                chk("R8 no done", done, 0);
                return;
            end
            if (i == n - 1) begin
                chk("R7 done", done, 1);
                chk("R7 busy low", busy, 0);
                @(negedge clk);
                chk("R7 done one cycle", done, 0);
            end else begin
                chk("R7 not done early", done, 0);
                chk("R8 no sync_err", sync_err, 0);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    chk("R5 hold without pulse", cur_addr, b + AW'(i + 1));
                end
            end
        end
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 addr_err", addr_err, 0);
        chk("R10 sync_err", sync_err, 0);
        chk("R10 is_preamble", is_preamble, 0);
        rst_n = 1'b1;
        // R5/R7: lengths across a track edge, both modes
        for (int w = 1021; w <= 1023; w++)
            for (int len = 0; len <= 4; len++)
                for (int rd = 0; rd < 2; rd++)
                    run_blk(mk(5, w), mk(5, w) + AW'(len), rd[0], 1'b1, len % 2, 1'b0);
        // R5: last valid track, top words
        run_blk(mk(383, 1020), mk(383, 1023), 1'b1, 1'b1, 0, 1'b0);
        run_blk(mk(0, 0), mk(0, 2), 1'b0, 1'b1, 1, 1'b0);
        // R8: read without preamble, write without preamble
        for (int len = 0; len <= 2; len++) begin
            run_blk(mk(12, 1023), mk(12, 1023) + AW'(len), 1'b1, 1'b0, 0, 1'b0);
            run_blk(mk(12, 1023), mk(12, 1023) + AW'(len), 1'b0, 1'b0, 0, 1'b0);
        end
        // R2: track range limits on both addresses
        run_blk(mk(384, 0), mk(384, 5), 1'b0, 1'b1, 0, 1'b0);
        run_blk(mk(383, 10), mk(384, 0), 1'b0, 1'b1, 0, 1'b0);
        run_blk(mk(511, 1023), mk(511, 1023), 1'b1, 1'b1, 0, 1'b0);
        run_blk(mk(383, 1023), mk(383, 1023), 1'b1, 1'b1, 0, 1'b0);
        // R3: reversed order
        run_blk(mk(9, 4), mk(9, 3), 1'b0, 1'b1, 0, 1'b0);
        run_blk(mk(10, 0), mk(9, 1023), 1'b1, 1'b1, 0, 1'b0);
        // R9: start during a transfer is ignored
        run_blk(mk(20, 1022), mk(21, 1), 1'b0, 1'b1, 0, 1'b1);
        chk("R9 idle after ignored start", busy, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule